// File: doc/BRIEF.md
# Grayscale PWM Channel Bank with Blanking

This block drives a bank of LED output enables by pulse-width modulation. A shared counter advances on each counting edge of a slow grayscale clock. Every channel turns on at the start of a period and turns off once the count reaches that channel's latched level. The counter wraps after 2^W counting edges, and that wrap starts the next period.

A blank input forces every output off and parks the period. When blank is released, the bank waits for one counting edge. It then starts the period on the opposite edge that follows. A polarity input chooses which grayscale edge counts. The grayscale clock is sampled by the system clock through a synchronizer, so the system clock must run at least four times faster. New levels are taken into a pending register with a load strobe. They become active only while blanked or at a period wrap, so a running period is never cut short. Outputs follow a grayscale edge within four system clocks.

Top module: `gs_pwm_bank`

## Requirements
- R1: While blank_i is high, led_on_o is all zero from the first system clock edge that samples it. led_on_o is all zero out of reset.
- R2: With edge_pol_i = 1 (the rising grayscale edge counts), a release of blank_i keeps the outputs off through the next rising edge. The outputs turn on at the first falling edge after that rising edge.
- R3: With edge_pol_i = 0 (the falling grayscale edge counts), a release of blank_i keeps the outputs off through the next falling edge. The outputs turn on at the first rising edge after that falling edge.
- R4: Channel i takes its level from level_i[i*W +: W] as an unsigned binary value. After k counting edges in a period, the channel is on exactly when k < level.
- R5: A channel whose active level is zero stays off for the whole period.
- R6: The period counter is W bits wide. After 2^W counting edges it returns to zero, and every channel with a nonzero level turns on again.
- R7: A load_i pulse copies level_i into a pending register. The pending value becomes active only while blank_i is high or at a period wrap. A load in the middle of a period has no effect before that period ends.
- R8: Releasing blank_i restarts the period from a count of zero, whatever count was reached before blanking.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| gs_clk_i | input | 1 | Grayscale clock, asynchronous and sampled |
| edge_pol_i | input | 1 | 1: the rising grayscale edge counts; 0: the falling edge counts |
| blank_i | input | 1 | Forces all outputs off and parks the period |
| load_i | input | 1 | Strobe that captures level_i into the pending register |
| level_i | input | NCH*W | Packed channel levels, W bits per channel |
| led_on_o | output | NCH | Channel output enables |

## Verification
The bench builds the bank with W = 4 and NCH = 4, so a full period takes only 16 counting edges. This puts the wrap, the deferred activation of new levels and the restart after blanking within a short run. The four levels 0, 1, 3 and 15 cover a channel that is never on, channels that switch off early, and a channel that stays on for all but the last slot. Both polarities are checked across the release sequence. At each step the outputs are checked before and after the aligning edge.

// File: rtl/gs_pwm_pkg.sv
package gs_pwm_pkg;
  typedef enum logic [1:0] {
    ST_BLANK = 2'd0,
    ST_ARM   = 2'd1,
    ST_ALIGN = 2'd2,
    ST_RUN   = 2'd3
  } gs_state_e;
endpackage

// File: rtl/gs_edge_sync.sv
module gs_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic gs_clk_i,
  input  logic pol_i,
  output logic count_edge_o,
  output logic align_edge_o
);
  // sh[STAGES-1] is the synced level, sh[STAGES] its previous value
  logic [STAGES:0] sh_q;
  logic rise, fall;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-1:0], gs_clk_i};
  end

  assign rise = sh_q[STAGES-1] & ~sh_q[STAGES];
  assign fall = ~sh_q[STAGES-1] & sh_q[STAGES];

  assign count_edge_o = pol_i ? rise : fall;
  assign align_edge_o = pol_i ? fall : rise;
endmodule

// File: rtl/gs_period_ctrl.sv
module gs_period_ctrl
  import gs_pwm_pkg::*;
#(
  parameter int W = 10
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         blank_i,
  input  logic         count_edge_i,
  input  logic         align_edge_i,
  output logic         run_o,
  output logic         blanked_o,
  output logic         wrap_o,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

  gs_state_e    state_q;
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_BLANK;
      cnt_q   <= '0;
    end else if (blank_i) begin
      state_q <= ST_BLANK;
      cnt_q   <= '0;
    end else begin
      unique case (state_q)
        ST_BLANK: state_q <= ST_ARM;
        ST_ARM:   if (count_edge_i) state_q <= ST_ALIGN;
        ST_ALIGN: if (align_edge_i) begin
          state_q <= ST_RUN;
          cnt_q   <= '0;
        end
        ST_RUN:   if (count_edge_i) cnt_q <= cnt_q + 1'b1;
        default:  state_q <= ST_BLANK;
      endcase
    end
  end

  assign run_o     = (state_q == ST_RUN);
  assign blanked_o = (state_q == ST_BLANK);
  assign wrap_o    = run_o && count_edge_i && (cnt_q == CNT_MAX) && !blank_i;
  assign cnt_o     = cnt_q;
endmodule

// File: rtl/gs_channel.sv
module gs_channel #(
  parameter int W = 10
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] level_i,
  input  logic         apply_i,
  input  logic         run_i,
  input  logic         blank_i,
  input  logic [W-1:0] cnt_i,
  output logic [W-1:0] active_o,
  output logic         on_o
);
  logic [W-1:0] pend_q, act_q;
  logic         on_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      act_q  <= '0;
      on_q   <= 1'b0;
    end else begin
      if (load_i)  pend_q <= level_i;
      if (apply_i) act_q  <= pend_q;
      on_q <= run_i & ~blank_i & (cnt_i < act_q);
    end
  end

  assign active_o = act_q;
  assign on_o     = on_q;
endmodule

// File: rtl/gs_pwm_bank.sv
module gs_pwm_bank #(
  parameter int NCH    = 8,
  parameter int W      = 10,
  parameter int STAGES = 2
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           gs_clk_i,
  input  logic           edge_pol_i,
  input  logic           blank_i,
  input  logic           load_i,
  input  logic [NCH*W-1:0] level_i,
  output logic [NCH-1:0] led_on_o
);
  logic         count_edge, align_edge;
  logic         run, blanked, wrap;
  logic [W-1:0] cnt;
  logic [NCH*W-1:0] active_flat;

  gs_edge_sync #(.STAGES(STAGES)) u_sync (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .gs_clk_i     (gs_clk_i),
    .pol_i        (edge_pol_i),
    .count_edge_o (count_edge),
    .align_edge_o (align_edge)
  );

  gs_period_ctrl #(.W(W)) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .blank_i      (blank_i),
    .count_edge_i (count_edge),
    .align_edge_i (align_edge),
    .run_o        (run),
    .blanked_o    (blanked),
    .wrap_o       (wrap),
    .cnt_o        (cnt)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    gs_channel #(.W(W)) u_ch (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .load_i   (load_i),
      .level_i  (level_i[i*W +: W]),
      .apply_i  (blanked | wrap),
      .run_i    (run),
      .blank_i  (blank_i),
      .cnt_i    (cnt),
      .active_o (active_flat[i*W +: W]),
      .on_o     (led_on_o[i])
    );
  end
endmodule

// File: rtl/gs_pwm_bank_chk.sv
module gs_pwm_bank_chk #(
  parameter int NCH = 8,
  parameter int W   = 10
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             blank_i,
  input logic [NCH-1:0]   led_on_o,
  input logic             run_i,
  input logic             blanked_i,
  input logic             wrap_i,
  input logic [W-1:0]     cnt_i,
  input logic [NCH*W-1:0] active_i
);
  // R1
  blank_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blank_i |=> (led_on_o == '0));

  // R2
  run_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (led_on_o != '0) |-> $past(run_i));

  // R8
  start_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(run_i) |-> (cnt_i == '0));

  // R6
  cnt_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && $past(run_i)) |-> (cnt_i == $past(cnt_i) || cnt_i == $past(cnt_i) + 1'b1));

  // R7
  defer_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(active_i) |-> $past(blanked_i || wrap_i));

  for (genvar i = 0; i < NCH; i++) begin : g_zero
    // R5
    zero_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      led_on_o[i] |-> ($past(active_i[i*W +: W]) != '0));
  end
endmodule

bind gs_pwm_bank gs_pwm_bank_chk #(.NCH(NCH), .W(W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .blank_i   (blank_i),
  .led_on_o  (led_on_o),
  .run_i     (run),
  .blanked_i (blanked),
  .wrap_i    (wrap),
  .cnt_i     (cnt),
  .active_i  (active_flat)
);

// File: tb/gs_pwm_bank_test.sv
module gs_pwm_bank_test;
  localparam int NCH = 4;
  localparam int W   = 4;
  localparam int PER = 1 << W;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic gs_clk = 1'b0;
  logic pol = 1'b1;
  logic blank = 1'b1;
  logic load = 1'b0;
  logic [NCH*W-1:0] level = '0;
  logic [NCH-1:0] led;

  int checks = 0;
  int fails  = 0;

  // channel 3..0 levels
  localparam logic [NCH*W-1:0] LV_A = {4'd15, 4'd3, 4'd1, 4'd0};
  localparam logic [NCH*W-1:0] LV_B = {4'd0, 4'd8, 4'd8, 4'd8};

  always #2ns clk = ~clk;

  gs_pwm_bank #(.NCH(NCH), .W(W)) uut (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .gs_clk_i   (gs_clk),
    .edge_pol_i (pol),
    .blank_i    (blank),
    .load_i     (load),
    .level_i    (level),
    .led_on_o   (led)
  );

  function automatic logic [NCH-1:0] mask(input int k, input logic [NCH*W-1:0] lv);
    logic [NCH-1:0] m;
    for (int i = 0; i < NCH; i++) m[i] = (k < int'(lv[i*W +: W]));
    return m;
  endfunction

  task automatic chk(input logic [NCH-1:0] exp, input string req);
    checks++;
    if (led !== exp) begin
      fails++;
      $display("FAIL %s: led_on_o=%b expected=%b", req, led, exp);
    end
  endtask

  task automatic gs_set(input logic v);
    @(negedge clk); gs_clk = v;
    repeat (6) @(negedge clk);
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_load(input logic [NCH*W-1:0] v);
    @(negedge clk); level = v; load = 1'b1;
    @(negedge clk); load = 1'b0;
  endtask

  task automatic t_reset;
    wait_clk(2);
    chk('0, "R1 reset");
    rst_ni = 1'b1;
    wait_clk(2);
    chk('0, "R1 after reset while blanked");
  endtask

  task automatic t_release_pol_high;
    pol = 1'b1;
    do_load(LV_A);
    wait_clk(3);
    @(negedge clk); blank = 1'b0;
    wait_clk(4);
    chk('0, "R2 off after release");
    gs_set(1'b1);
    chk('0, "R2 off after first rising edge");
    gs_set(1'b0);
    chk(mask(0, LV_A), "R2 on at falling edge");
    chk(mask(0, LV_A) & 4'b0001 ^ mask(0, LV_A), "R5 zero level channel off");
  endtask

  task automatic t_pwm_period;
    for (int k = 1; k <= PER; k++) begin
      gs_set(1'b1);
      if (k == PER) chk(mask(0, LV_A), "R6 wrap restarts period");
      else          chk(mask(k, LV_A), "R4 count vs level");
      if (led[0])   chk(led & 4'b1110, "R5 zero level channel lit");
      gs_set(1'b0);
    end
  endtask

  task automatic t_blank;
    @(negedge clk); blank = 1'b1;
    @(negedge clk);
    chk('0, "R1 blank forces off");
    gs_set(1'b1);
    gs_set(1'b0);
    chk('0, "R1 stays off with grayscale edges");
  endtask

  task automatic t_restart;
    @(negedge clk); blank = 1'b0;
    gs_set(1'b1);
    gs_set(1'b0);
    chk(mask(0, LV_A), "R8 first period start");
    gs_set(1'b1); gs_set(1'b0);
    gs_set(1'b1); gs_set(1'b0);
    chk(mask(2, LV_A), "R8 count reached two");
    @(negedge clk); blank = 1'b1;
    wait_clk(3);
    @(negedge clk); blank = 1'b0;
    gs_set(1'b1);
    gs_set(1'b0);
    chk(mask(0, LV_A), "R8 restart from zero");
    gs_set(1'b1);
    chk(mask(1, LV_A), "R8 first edge after restart");
    gs_set(1'b0);
  endtask

  task automatic t_release_pol_low;
    @(negedge clk); blank = 1'b1; pol = 1'b0;
    wait_clk(3);
    @(negedge clk); blank = 1'b0;
    wait_clk(4);
    gs_set(1'b1);
    chk('0, "R3 rising edge before falling ignored");
    gs_set(1'b0);
    chk('0, "R3 off after first falling edge");
    gs_set(1'b1);
    chk(mask(0, LV_A), "R3 on at rising edge");
    gs_set(1'b0);
    chk(mask(1, LV_A), "R3 falling edge counts");
  endtask

  task automatic t_deferred_load;
    do_load(LV_B);
    wait_clk(2);
    chk(mask(1, LV_A), "R7 load has no effect mid-period");
    for (int k = 2; k <= PER; k++) begin
      gs_set(1'b1);
      gs_set(1'b0);
      if (k == PER) chk(mask(0, LV_B), "R7 new levels at wrap");
      else if (k == 2 || k == 3 || k == 15) chk(mask(k, LV_A), "R7 old levels kept");
    end
    for (int k = 1; k <= 8; k++) begin
      gs_set(1'b1);
      gs_set(1'b0);
      if (k == 7 || k == 8) chk(mask(k, LV_B), "R7 new levels applied");
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish, actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_release_pol_high();
    t_pwm_period();
    t_blank();
    t_restart();
    t_release_pol_low();
    t_deferred_load();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule